// File: doc/BRIEF.md
# Diagnostic Event Interrupt Aggregator

This block watches a vector of live diagnostic signals and turns selected transitions on them into a single interrupt line. Every cycle, each signal is compared with its value from the previous cycle. A transition of the chosen polarity latches a pending flag for that signal. For the lower signals software picks rising or falling per bit. The upper signals always trigger on a rising transition.

Pending flags stay set until software writes a one to them. A per-bit enable vector selects which pending flags feed the interrupt. The interrupt is the registered OR of all enabled pending flags. Software uses a small word-addressed register port with a write strobe, a two-bit address and a combinational read. The port reaches four locations: the live signal levels at address 0 (read-only), polarity select at 1, enable at 2 and pending (write-one-to-clear) at 3.

Top module: `diag_evt_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, the polarity, enable and pending registers read 0 and `irq_o` is 0.
- R2: On a lower bit (0 to 7) whose polarity bit is 0, a 0-to-1 transition of the input sets its pending bit on the clock edge that first samples the new level.
- R3: On a lower bit whose polarity bit is 1, a 1-to-0 transition sets its pending bit, and a 0-to-1 transition does not.
- R4: Bits 8 to 10 set their pending bit on a 0-to-1 transition only. Their positions in the polarity register ignore writes and read 0.
- R5: A pending bit stays set after its input returns to its former level, and only a transition sets it. A steady level never does.
- R6: Writing address 3 clears every pending bit whose data bit is 1. Bits written with 0 are unchanged.
- R7: If a qualifying transition and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: `irq_o` equals the OR over all bits of (pending AND enable), delayed by one clock.
- R9: An enable bit of 0 keeps its pending bit from raising `irq_o`, but the pending bit still records events.
- R10: A read of address 0 returns the current input levels in bits 0 to 10. A write to address 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| diag_in | input | 11 | Live diagnostic signal levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 live, 1 polarity, 2 enable, 3 pending) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational, zero-extended |
| irq_o | output | 1 | Registered interrupt |

## Verification
The bench builds the block with its default parameters: 11 events, 8 of them with selectable polarity, and a 16-bit data path. With these values both polarity choices, the fixed-rising upper group and the ignored upper bits of the polarity register can be reached from the ports. The vector walk covers rising and falling detection, the steady levels that must not set anything, partial clears and a clear that coincides with a new edge. Directed steps then check the reset values, the live read and the one-cycle lag of the interrupt as enables change.

// File: rtl/diag_irq_pkg.sv
// Shared definitions for the diagnostic event interrupt aggregator.
// Assumes a two-bit word address on the register port.
package diag_irq_pkg;
    typedef enum logic [1:0] {
        REG_LIVE = 2'd0,
        REG_POL  = 2'd1,
        REG_EN   = 2'd2,
        REG_PEND = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/diag_edge_detect.sv
// Per-bit transition detector.
// Compares each input with its value sampled on the previous clock. Bits
// below N_POL use a polarity select (0 rising, 1 falling). The remaining bits
// detect rising transitions only.
// Assumes the inputs are already synchronous to clk.
module diag_edge_detect #(
    parameter int N_EVT = 11,
    parameter int N_POL = 8
) (
    input  logic             clk,
    input  logic [N_EVT-1:0] sig_i,
    input  logic [N_POL-1:0] fall_sel_i,
    output logic [N_EVT-1:0] evt_o
);
    logic [N_EVT-1:0] prev_q;

    // Hold the previous level. No reset: the register tracks the inputs during reset too.
    always_ff @(posedge clk) begin
        prev_q <= sig_i;
    end

    for (genvar i = 0; i < N_EVT; i++) begin : g_bit
        if (i < N_POL) begin : g_sel
            assign evt_o[i] = fall_sel_i[i] ? (prev_q[i] & ~sig_i[i])
                                            : (~prev_q[i] & sig_i[i]);
        end else begin : g_rise
            assign evt_o[i] = ~prev_q[i] & sig_i[i];
        end
    end
endmodule

// File: rtl/diag_pend_bank.sv
// Sticky pending flags with write-one-to-clear.
// A new event on a bit takes priority over a clear of that bit in the same cycle.
module diag_pend_bank #(
    parameter int N_EVT = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_i,
    input  logic [N_EVT-1:0] clr_i,
    output logic [N_EVT-1:0] pend_o
);
    logic [N_EVT-1:0] pend_q;

    // Latch events and apply clears. Set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | evt_i;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/diag_reg_port.sv
// Register port: holds the polarity and enable registers, decodes the pending
// clear, and multiplexes read data.
// Assumes DATA_W > N_EVT. Unused write-data bits are ignored.
module diag_reg_port
    import diag_irq_pkg::*;
#(
    parameter int N_EVT  = 11,
    parameter int N_POL  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N_EVT-1:0]  live_i,
    input  logic [N_EVT-1:0]  pend_i,
    output logic [N_POL-1:0]  pol_o,
    output logic [N_EVT-1:0]  en_o,
    output logic [N_EVT-1:0]  clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    reg_sel_e         sel;
    logic [N_POL-1:0] pol_q;
    logic [N_EVT-1:0] en_q;
    logic             unused_wdata;

    assign sel          = reg_sel_e'(addr_i);
    assign unused_wdata = ^wdata_i[DATA_W-1:N_EVT];

    // Write the polarity and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
            en_q  <= '0;
        end else if (wr_i) begin
            if (sel == REG_POL) pol_q <= wdata_i[N_POL-1:0];
            if (sel == REG_EN)  en_q  <= wdata_i[N_EVT-1:0];
        end
    end

    // Turn a write to the pending address into a clear vector.
    always_comb begin
        clr_o = '0;
        if (wr_i && sel == REG_PEND) clr_o = wdata_i[N_EVT-1:0];
    end

    // Select read data, zero-extended.
    always_comb begin
        rdata_o = '0;
        unique case (sel)
            REG_LIVE: rdata_o[N_EVT-1:0] = live_i;
            REG_POL:  rdata_o[N_POL-1:0] = pol_q;
            REG_EN:   rdata_o[N_EVT-1:0] = en_q;
            REG_PEND: rdata_o[N_EVT-1:0] = pend_i;
            default:  rdata_o = '0;
        endcase
    end

    assign pol_o = pol_q;
    assign en_o  = en_q;
endmodule

// File: rtl/diag_evt_irq_agg.sv
// Top level: collects transitions on the diagnostic inputs into pending flags
// and drives one registered interrupt from the enabled pending flags.
// Assumes diag_in is synchronous to clk. The reset is synchronous and active-low.
module diag_evt_irq_agg #(
    parameter int N_EVT  = 11,
    parameter int N_POL  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  diag_in,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    logic [N_EVT-1:0] evt_w;
    logic [N_EVT-1:0] clr_w;
    logic [N_EVT-1:0] pend_w;
    logic [N_EVT-1:0] en_w;
    logic [N_POL-1:0] pol_w;
    logic             irq_q;

    diag_edge_detect #(.N_EVT(N_EVT), .N_POL(N_POL)) edge_i (
        .clk        (clk),
        .sig_i      (diag_in),
        .fall_sel_i (pol_w),
        .evt_o      (evt_w)
    );

    diag_pend_bank #(.N_EVT(N_EVT)) pend_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_w),
        .clr_i  (clr_w),
        .pend_o (pend_w)
    );

    diag_reg_port #(.N_EVT(N_EVT), .N_POL(N_POL), .DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .live_i  (diag_in),
        .pend_i  (pend_w),
        .pol_o   (pol_w),
        .en_o    (en_w),
        .clr_o   (clr_w),
        .rdata_o (reg_rdata)
    );

    // Register the OR of the enabled pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend_w & en_w);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/diag_evt_irq_agg_chk.sv
// Assertion checker for diag_evt_irq_agg, attached by bind below.
module diag_evt_irq_agg_chk #(
    parameter int N_EVT = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_EVT-1:0] evt,
    input logic [N_EVT-1:0] clr,
    input logic [N_EVT-1:0] pend,
    input logic [N_EVT-1:0] en,
    input logic             irq_o
);
    // R1
    reset_irq_low_chk: assert property (@(posedge clk)
        !rst_n |=> !irq_o);

    // R7
    event_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

    // R6
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(pend) & ~pend & ~$past(clr)) == '0));

    // R8
    irq_follows_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_o == $past(|(pend & en))));

    // R9
    masked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & en) == '0) |=> !irq_o);
endmodule

bind diag_evt_irq_agg diag_evt_irq_agg_chk #(.N_EVT(N_EVT)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_w),
    .clr   (clr_w),
    .pend  (pend_w),
    .en    (en_w),
    .irq_o (irq_o)
);

// File: tb/diag_evt_irq_agg_tb_top.sv
`timescale 1ns/1ps
module diag_evt_irq_agg_tb_top;
    localparam int N_EVT  = 11;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N_EVT-1:0]  diag_in;
    logic              reg_wr;
    logic [1:0]        reg_addr;
    logic [DATA_W-1:0] reg_wdata;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_o;

    int n_chk = 0;
    int n_err = 0;
    logic [DATA_W-1:0] rv;

    always #4 clk = ~clk;

    diag_evt_irq_agg dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .diag_in   (diag_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    // Each entry: {input levels, clear data, expected pending} with polarity 0x0F0.
    localparam logic [32:0] VEC [0:10] = '{
        {11'h00F, 11'h000, 11'h00F},  // R2 rising on bits 0-3
        {11'h0F0, 11'h000, 11'h00F},  // R3 rising on falling-select bits ignored
        {11'h000, 11'h000, 11'h0FF},  // R3 falling on bits 4-7
        {11'h700, 11'h000, 11'h7FF},  // R4 upper bits rising
        {11'h000, 11'h000, 11'h7FF},  // R5 sticky, R4 upper falling ignored
        {11'h000, 11'h7FF, 11'h000},  // R6 clear all
        {11'h005, 11'h000, 11'h005},  // R2
        {11'h005, 11'h001, 11'h004},  // R6 partial clear, R5 steady level
        {11'h000, 11'h000, 11'h004},  // R5 falling on rising-select ignored
        {11'h400, 11'h004, 11'h400},  // R6 clear plus R4 event
        {11'h401, 11'h001, 11'h401}   // R7 edge beats same-cycle clear
    };

    task automatic check(input string what, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; diag_in = '0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd1, rv); check("R1 polarity reset", rv, 16'h0);
        rd(2'd2, rv); check("R1 enable reset", rv, 16'h0);
        rd(2'd3, rv); check("R1 pending reset", rv, 16'h0);
        check("R1 irq reset", {15'h0, irq_o}, 16'h0);

        // R4: upper polarity positions ignore writes.
        wr(2'd1, 16'hFFFF);
        rd(2'd1, rv); check("R4 polarity upper bits", rv, 16'h00FF);
        wr(2'd1, 16'h00F0);
        wr(2'd2, 16'h07FF);

        // R10: live read and ignored write.
        @(negedge clk); diag_in = 11'h2A5;
        rd(2'd0, rv); check("R10 live read", rv, 16'h02A5);
        wr(2'd0, 16'h0000);
        rd(2'd0, rv); check("R10 live write ignored", rv, 16'h02A5);
        @(negedge clk); diag_in = '0;
        @(negedge clk);
        wr(2'd3, 16'h07FF);

        for (int k = 0; k < 11; k++) begin
            @(negedge clk);
            diag_in = VEC[k][32:22];
            if (VEC[k][21:11] != '0) begin
                reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = {5'h0, VEC[k][21:11]};
            end
            @(negedge clk);
            reg_wr = 1'b0;
            rd(2'd3, rv);
            check($sformatf("R2-R7 vector %0d pending", k), rv, {5'h0, VEC[k][10:0]});
        end

        // Pending is 0x401 here with input 0x401.
        wr(2'd2, 16'h0000);
        @(negedge clk);
        check("R9 all disabled irq", {15'h0, irq_o}, 16'h0);
        rd(2'd3, rv); check("R9 pending kept while disabled", rv, 16'h0401);
        wr(2'd2, 16'h0002);
        @(negedge clk);
        check("R9 enabled bit not pending", {15'h0, irq_o}, 16'h0);
        wr(2'd2, 16'h0400);
        check("R8 irq lags enable by one clock", {15'h0, irq_o}, 16'h0);
        @(negedge clk);
        check("R8 irq raised", {15'h0, irq_o}, 16'h1);
        wr(2'd3, 16'h0400);
        check("R8 irq still high one clock after clear", {15'h0, irq_o}, 16'h1);
        @(negedge clk);
        check("R8 irq dropped after clear", {15'h0, irq_o}, 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule